// File: doc/BRIEF.md
# Gapped-Clock Jitter Attenuator FIFO

This block smooths the timing of one 2.048 Mbps dual-rail data stream. Each write strobe stores a pair of rail bits into an elastic buffer. The write strobes may be jittery, or may arrive in bursts separated by gaps. A read strobe comes out at a steady rate, and the pair of bits leaves the buffer on that strobe. The read strobe is made from the single high-rate clock by a phase accumulator. Each clock the accumulator adds an increment, and every carry out of it is one read. The increment is a nominal value plus a correction that grows with the distance of the fill level from half depth. Because of this, the buffer settles at half depth, and the throughput delay is half the selected depth.

When the fill comes within two entries of empty or of full, the correction gain rises by a factor of eight. The read rate then follows the write rate closely, so that data is not lost. Normal, gentle attenuation comes back once the fill is outside that guard band again. The buffer depth can be set to 32 or 64 entries. Changing the depth, or holding the bypass input, re-centres the buffer. Bypass sends the input strobe and data straight to the output. Sticky flags report when a write was dropped because the buffer was full, or a read was made while it was empty. A status-read pulse clears both flags.

Top module: `ja_fifo`

## Requirements
- R1: While reset is held, rd_en is 0, rd_data is 00, ovf, unf and wide_mode are 0, and the fill stands at 16 (depth 32).
- R2: Entries come out in write order. After reset, after a depth change or after bypass is released, the first D/2 reads return 00, where D is 32 when deep=0 and 64 when deep=1. This gives a throughput delay of D/2 entries.
- R3: A write that arrives while the fill equals D is dropped, and ovf sets on the next clock and stays set.
- R4: A read strobe that fires while the fill is 0 returns 00 and sets unf. Read strobes keep coming while the buffer is empty.
- R5: A one-clock stat_rd pulse clears ovf and unf on the next clock, unless a new event of that kind happens in the same clock. Otherwise the flags hold.
- R6: wide_mode is 1 exactly when the fill is at most 2 or at least D-2.
- R7: With default parameters, in narrow mode, consecutive read strobes are 7 to 9 clocks apart. The nominal spacing is 2^ACC_W/NOM_INC = 8.
- R8: In wide mode the correction gain is 8 per entry instead of 1. With the fill held at D-2 or above, strobe spacings of 6 clocks or fewer occur, which narrow mode never produces.
- R9: A write pattern of G-UI gaps alternating with G-UI bursts of 2G writes, entered after a gap of G/2 UI, sets neither flag. G is 20 at depth 32 and 50 at depth 64.
- R10: While bypass=1, rd_en equals wr_en and rd_data equals wr_data within the same clock.
- R11: A change of deep, or any clock with bypass=1, re-centres the buffer at D/2 of the new depth and restarts the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one entry per high clock |
| wr_data | input | 2 | Positive and negative rail bits |
| deep | input | 1 | Depth select: 0 for 32 entries, 1 for 64 |
| bypass | input | 1 | Route input straight to output |
| stat_rd | input | 1 | Clear pulse for the sticky flags |
| rd_en | output | 1 | Smoothed read strobe |
| rd_data | output | 2 | Rail bits read out with rd_en |
| wide_mode | output | 1 | Fill is inside the guard band |
| ovf | output | 1 | Sticky: a write was dropped |
| unf | output | 1 | Sticky: a read was made while empty |

## Verification
The bench uses the default parameters. AW=6 makes both the 32-entry and 64-entry depths available. ACC_W=12 with NOM_INC=512 gives one read every eight clocks. At that rate the bench can follow every read against an arithmetic fill model and a queue of the written data, clock by clock. The 20-UI and 50-UI gap patterns, the overflow and underflow corners, and the wide-gain spacing all fit in a short run. The guard band, the flags and each data value are compared on every clock, and the strobe spacing is compared on every read.

// File: rtl/ja_fifo.sv
module ja_fifo #(
  parameter int AW        = 6,
  parameter int ACC_W     = 12,
  parameter int NOM_INC   = 512,
  parameter int NARROW_SH = 0,
  parameter int WIDE_SH   = 3,
  parameter int GUARD     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       deep,
  input  logic       bypass,
  input  logic       stat_rd,
  output logic       rd_en,
  output logic [1:0] rd_data,
  output logic       wide_mode,
  output logic       ovf,
  output logic       unf
);
  localparam int CW   = AW + 1;
  localparam int NENT = 1 << AW;
  localparam int IW   = ACC_W + CW + WIDE_SH + 2;
  localparam logic [CW-1:0] BIG   = CW'(NENT);
  localparam logic [CW-1:0] SMALL = CW'(NENT / 2);
  localparam logic signed [IW-1:0] INC_MAX = IW'((1 << ACC_W) - 1);

  logic             deep_q, rd_q;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    wptr, rptr;
  logic [ACC_W-1:0] acc;
  logic [1:0]       data_q;
  logic [1:0]       mem [NENT];

  logic [CW-1:0]        depth, depth_n, half, half_n;
  logic [AW-1:0]        mask;
  logic                 reinit, empty, full, fire, rd_ok, wr_ok;
  logic signed [IW-1:0] err, corr, inc_s;
  logic [ACC_W-1:0]     inc;
  logic [ACC_W:0]       sum;

  assign depth   = deep_q ? BIG : SMALL;
  assign depth_n = deep ? BIG : SMALL;
  assign half    = depth >> 1;
  assign half_n  = depth_n >> 1;
  assign mask    = AW'(depth - CW'(1));
  assign reinit  = bypass | (deep != deep_q);
  assign empty   = (cnt == '0);
  assign full    = (cnt == depth);

  assign wide_mode = (cnt <= CW'(GUARD)) | (cnt >= depth - CW'(GUARD));

  assign err   = $signed(IW'(cnt)) - $signed(IW'(half));
  assign corr  = wide_mode ? (err <<< WIDE_SH) : (err <<< NARROW_SH);
  assign inc_s = $signed(IW'(NOM_INC)) + corr;

  always_comb begin
    if (inc_s < 0)            inc = '0;
    else if (inc_s > INC_MAX) inc = INC_MAX[ACC_W-1:0];
    else                      inc = inc_s[ACC_W-1:0];
  end

  assign sum   = {1'b0, acc} + {1'b0, inc};
  assign fire  = sum[ACC_W];
  assign rd_ok = fire & ~empty;
  assign wr_ok = wr_en & ~full;

  assign rd_en   = bypass ? wr_en : rd_q;
  assign rd_data = bypass ? wr_data : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q <= 1'b0;
      cnt    <= SMALL >> 1;
      wptr   <= AW'(NENT / 4);
      rptr   <= '0;
      acc    <= '0;
      rd_q   <= 1'b0;
      data_q <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      for (int i = 0; i < NENT; i++) mem[i] <= '0;
    end else begin
      deep_q <= deep;
      ovf    <= (ovf & ~stat_rd) | (~reinit & wr_en & full);
      unf    <= (unf & ~stat_rd) | (~reinit & fire & empty);
      if (reinit) begin
        cnt    <= half_n;
        wptr   <= AW'(half_n);
        rptr   <= '0;
        acc    <= '0;
        rd_q   <= 1'b0;
        data_q <= '0;
        for (int i = 0; i < NENT; i++) mem[i] <= '0;
      end else begin
        acc  <= sum[ACC_W-1:0];
        rd_q <= fire;
        if (fire) data_q <= empty ? 2'b00 : mem[rptr];
        if (rd_ok) rptr <= (rptr + AW'(1)) & mask;
        if (wr_ok) begin
          mem[wptr] <= wr_data;
          wptr      <= (wptr + AW'(1)) & mask;
        end
        cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
      end
    end
  end
endmodule

// File: rtl/ja_fifo_chk.sv
module ja_fifo_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bypass,
  input logic          reinit,
  input logic          stat_rd,
  input logic          rd_en,
  input logic [1:0]    rd_data,
  input logic          ovf,
  input logic          unf,
  input logic          fire,
  input logic          empty,
  input logic [AW:0]   cnt,
  input logic [AW:0]   half_n
);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(1 << AW));

  p_under_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reinit && fire && empty) |=> (bypass || (rd_data == 2'b00 && unf && rd_en)));

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !stat_rd) |=> ovf);

  p_unf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !stat_rd) |=> unf);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && rd_en) |=> (bypass || !rd_en));

  p_recentre_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (cnt == $past(half_n)));
endmodule

bind ja_fifo ja_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .reinit(reinit), .stat_rd(stat_rd),
  .rd_en(rd_en), .rd_data(rd_data), .ovf(ovf), .unf(unf), .fire(fire),
  .empty(empty), .cnt(cnt), .half_n(half_n)
);

// File: tb/ja_fifo_bench.sv
`timescale 1ns/1ps
module ja_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, deep = 1'b0, bypass = 1'b0, stat_rd = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic rd_en, wide_mode, ovf, unf;
  logic [1:0] rd_data;

  ja_fifo u_ja_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .deep(deep),
    .bypass(bypass), .stat_rd(stat_rd), .rd_en(rd_en), .rd_data(rd_data),
    .wide_mode(wide_mode), .ovf(ovf), .unf(unf)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int dep = 32, fill = 16, since = 0, min_wide = 99;
  logic [1:0] q[$];
  bit first_iv = 1, any_wide = 0, wide_prev = 0, reinit_pend = 0, measure_hi = 0;
  bit ovf_m = 0, unf_m = 0;

  task automatic init_model(input int d);
    fill = d / 2;
    q.delete();
    for (int i = 0; i < d / 2; i++) q.push_back(2'b00);
    since = 0;
    first_iv = 1;
    any_wide = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      init_model(32);
      ovf_m = 0;
      unf_m = 0;
    end else if (bypass || reinit_pend) begin
      ovf_m = ovf_m & ~stat_rd;
      unf_m = unf_m & ~stat_rd;
      init_model(dep);
      reinit_pend = 0;
    end else begin
      bit rd, wr, ev_o, ev_u;
      logic [1:0] expd;
      rd   = rd_en && fill > 0;
      wr   = wr_en && fill < dep;
      ev_o = wr_en && fill == dep;
      ev_u = rd_en && fill == 0;
      if (rd_en) begin
        expd = rd ? q.pop_front() : 2'b00;
        chk(rd_data == expd, rd ? "R2/R11 read order" : "R4 empty read", rd_data, expd);
      end
      if (wr) q.push_back(wr_data);
      fill += int'(wr) - int'(rd);
      ovf_m = (ovf_m & ~stat_rd) | ev_o;
      unf_m = (unf_m & ~stat_rd) | ev_u;
      chk(ovf == ovf_m, "R3/R5 ovf flag", ovf, ovf_m);
      chk(unf == unf_m, "R4/R5 unf flag", unf, unf_m);
      since++;
      any_wide |= wide_prev;
      if (rd_en) begin
        if (!first_iv) begin
          if (!any_wide) chk(since >= 7 && since <= 9, "R7 narrow spacing", since, 8);
          else if (measure_hi && since < min_wide) min_wide = since;
        end
        first_iv = 0;
        since = 0;
        any_wide = 0;
      end
    end
    chk(wide_mode == (fill <= 2 || fill >= dep - 2), "R6 guard band", wide_mode, fill);
    wide_prev = wide_mode;
  end

  function automatic logic [1:0] pat(input int i);
    return 2'((i ^ (i >> 2)) + (i >> 4));
  endfunction

  int wcount = 0;
  task automatic wr1();
    wr_en = 1'b1;
    wr_data = pat(wcount);
    wcount++;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) begin wr1(); repeat (7) @(negedge clk); end
  endtask

  task automatic gapped(input int g, input int periods);
    repeat (g * 4) @(negedge clk);
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < 2 * g; i++) begin wr1(); repeat (3) @(negedge clk); end
      repeat (g * 8) @(negedge clk);
    end
  endtask

  task automatic pulse_clear();
    while (!rd_en) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(rd_en == 1'b0 && rd_data == 2'b00, "R1 reset outputs", {rd_en, rd_data}, 0);
      chk(ovf == 1'b0 && unf == 1'b0 && wide_mode == 1'b0, "R1 reset flags", {ovf, unf, wide_mode}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    stream(300);
    gapped(20, 6);
    chk(ovf == 1'b0 && unf == 1'b0, "R9 gap 20 at depth 32", {ovf, unf}, 0);

    deep = 1'b1;
    dep = 64;
    reinit_pend = 1;
    @(negedge clk);
    stream(200);
    gapped(50, 4);
    chk(ovf == 1'b0 && unf == 1'b0, "R9 gap 50 at depth 64", {ovf, unf}, 0);

    for (int we = 0; we < 2; we++)
      for (int d = 0; d < 4; d++) begin
        bypass = 1'b1;
        wr_en = we[0];
        wr_data = 2'(d);
        #1;
        chk(rd_en == we[0] && rd_data == 2'(d), "R10 bypass path", {rd_en, rd_data}, {we[0], 2'(d)});
        @(negedge clk);
      end
    wr_en = 1'b0;
    bypass = 1'b0;
    stream(100);

    repeat (700) @(negedge clk);
    chk(unf == 1'b1, "R4 underflow flag", unf, 1);
    chk(rd_data == 2'b00, "R4 empty data", rd_data, 0);
    pulse_clear();
    chk(unf == 1'b0, "R5 unf cleared", unf, 0);

    for (int i = 0; i < 90; i++) wr1();
    chk(ovf == 1'b1, "R3 overflow flag", ovf, 1);
    measure_hi = 1;
    for (int i = 0; i < 400; i++) begin
      if (rd_en) begin wr_en = 1'b1; wr_data = pat(wcount); wcount++; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    measure_hi = 0;
    chk(min_wide <= 6, "R8 wide spacing", min_wide, 6);
    pulse_clear();
    chk(ovf == 1'b0, "R5 ovf cleared", ovf, 0);
    repeat (800) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule